// File: doc/BRIEF.md
# Batched Byte-Queue SPI Master

This block is an SPI master that runs a short batch of serial transfers on its own once software has loaded it. Software programs a mode register with the serial clock divider, the clock polarity and phase, the word length and a master-enable bit. It then loads up to sixteen queue entries into three small on-block memories: a command word per entry, a transmit word per entry, and a receive slot per entry. An address register selects which memory, and which entry, a single data register reaches. Each data access steps the entry index forward by one.

Software writes the index of the last entry to run into the queue-limit register and sets the go bit. The engine then walks the entries from index 0 up to that limit. For each entry it drives the chip-select lines named by the command word, shifts the transmit word out MSB first, and stores the word it samples from the slave into the receive slot of the same index. A sticky done flag rises after the last entry. Software clears that flag by writing a 1 to it, then reads the received words back through the data register.

Top module: `sbm_top`

## Requirements
- R1: Register addresses are 0 mode, 1 control, 2 queue-limit, 3 status, 4 address, 5 data. The address register holds a region in bits [5:4] (0 transmit, 1 receive, 2 command, 3 none) and an entry index in bits [3:0]. Every read or write of the data register advances the index by one. A data read in region 3 returns 0. After reset, mode reads 0x0000, queue-limit reads 0x0100, status reads 0, and all chip selects sit at 1.
- R2: Writing 1 to control bit 0 starts the queue at entry 0, but only while mode bit 14 (master enable) is 1. Control bit 0 reads 1 while the queue runs and returns to 0 by itself when the queue ends. Without master enable the write does nothing and no clock edges appear.
- R3: Status bit 0 sets when the last entry finishes. Writing 1 to it clears it. Writing 0 leaves it set.
- R4: Each entry shifts out the low bits of its transmit word, MSB first. The receive slot with the same index gets the bits sampled on MISO, right-aligned, with the upper bits zero. The receive slot is written even when software never reads it.
- R5: Mode bit 13 (CPOL) sets the idle level of the serial clock. With mode bit 12 (CPHA) at 0, data is sampled on the leading clock edge. With CPHA at 1, data is sampled on the trailing clock edge.
- R6: Command bit 4 (length-enable) makes an entry use the mode length field in bits [11:8], where 0 means 16 bits. When command bit 4 is clear, the entry is 8 bits long.
- R7: Each serial clock half-period lasts 2·D bus clocks, where D is mode bits [7:0]. Values of D below 2 act as 2.
- R8: Command bits [3:0] select which chip selects an entry asserts. Queue-limit bit 8 gives the idle level of every chip select, and an asserted line takes the opposite level. With command bit 5 (continue) set, the selects stay asserted into the next entry. Without it, the selects return to idle between entries. All selects are idle once the queue ends.
- R9: While the queue runs, writes to the mode register, the queue-limit register and the three memories are ignored.
- R10: The queue-limit register bits [3:0] give the index of the last entry. A value of 15 runs all sixteen entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (steps the index on data reads) |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_o | output | 4 | Chip-select lines |

## Verification
The bench loops MISO back to MOSI, either directly or inverted. The direct loop confirms that the sampling edge sees stable data. The inverted loop shows that the receive slots hold captured bits, not a copy of the transmit words. A bench monitor records MOSI on the sampling edge of each mode, so the shifted bit stream is compared on its own. Mixed 8-, 12- and 16-bit entries separate the length-enable path from the default length. Runs with continue set and cleared, with both chip-select idle levels, separate held selects from selects that drop between entries.

// File: rtl/sbm_pkg.sv
package sbm_pkg;

    localparam int REG_W    = 16;
    localparam int CS_N     = 4;
    localparam int NUM_RGN  = 3;
    localparam int LEN_W    = 5;
    localparam int DIV_W    = 8;
    localparam int HALF_W   = DIV_W + 1;

    // register select codes
    localparam logic [2:0] RA_MODE = 3'd0;
    localparam logic [2:0] RA_CTRL = 3'd1;
    localparam logic [2:0] RA_WRAP = 3'd2;
    localparam logic [2:0] RA_STAT = 3'd3;
    localparam logic [2:0] RA_ADDR = 3'd4;
    localparam logic [2:0] RA_DATA = 3'd5;

    // memory regions reached through the data register
    localparam logic [1:0] RG_TX   = 2'd0;
    localparam logic [1:0] RG_RX   = 2'd1;
    localparam logic [1:0] RG_CMD  = 2'd2;
    localparam logic [1:0] RG_NONE = 2'd3;

    typedef struct packed {
        logic             mstr;
        logic             cpol;
        logic             cpha;
        logic [3:0]       bits;
        logic [DIV_W-1:0] div;
    } mode_t;

    typedef struct packed {
        logic            cont;
        logic            bitse;
        logic [CS_N-1:0] sel;
    } cmd_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_LEAD,
        ST_TRAIL,
        ST_NEXT,
        ST_GAP
    } eng_state_e;

    // word length of one entry
    function automatic logic [LEN_W-1:0] entry_len(input logic bitse, input logic [3:0] bits);
        if (!bitse)
            return LEN_W'(8);
        else if (bits == 4'd0)
            return LEN_W'(16);
        else
            return {1'b0, bits};
    endfunction

    // bus clocks per serial half-period
    function automatic logic [HALF_W-1:0] half_cycles(input logic [DIV_W-1:0] div);
        if (div < DIV_W'(2))
            return HALF_W'(4);
        else
            return {div, 1'b0};
    endfunction

endpackage

// File: rtl/sbm_qram.sv
module sbm_qram #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/sbm_tick.sv
module sbm_tick
    import sbm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [HALF_W-1:0] cnt;
    logic [HALF_W-1:0] half;

    assign half = half_cycles(div);
    assign tick = run && (cnt == half - HALF_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (cnt == half - HALF_W'(1))
            cnt <= '0;
        else
            cnt <= cnt + HALF_W'(1);
    end

    AST_TICK_WINDOW: assert property (@(posedge clk) disable iff (rst)
        run |-> cnt < half); // R7

endmodule

// File: rtl/sbm_regfile.sv
module sbm_regfile
    import sbm_pkg::*;
#(
    parameter int QDEPTH = 16,
    localparam int IDXW  = $clog2(QDEPTH)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        reg_wr,
    input  logic                        reg_rd,
    input  logic [2:0]                  reg_addr,
    input  logic [REG_W-1:0]            reg_wdata,
    output logic [REG_W-1:0]            reg_rdata,
    input  logic                        busy,
    input  logic                        finish,
    input  logic [NUM_RGN-1:0][REG_W-1:0] ram_rd,
    output mode_t                       mode_q,
    output logic                        csiv_q,
    output logic [IDXW-1:0]             endp_q,
    output logic                        start,
    output logic [NUM_RGN-1:0]          sw_we,
    output logic [IDXW-1:0]             sw_idx
);

    logic [1:0] region_q;
    logic       done_q;
    logic       data_acc;

    assign data_acc = (reg_wr || reg_rd) && (reg_addr == RA_DATA);
    assign start    = reg_wr && (reg_addr == RA_CTRL) && reg_wdata[0] && mode_q.mstr && !busy;

    for (genvar g = 0; g < NUM_RGN; g++) begin : g_we
        assign sw_we[g] = reg_wr && (reg_addr == RA_DATA) && !busy && (region_q == 2'(g));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= '0;
            csiv_q   <= 1'b1;
            endp_q   <= '0;
            region_q <= RG_TX;
            sw_idx   <= '0;
            done_q   <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == RA_MODE && !busy)
                mode_q <= mode_t'(reg_wdata[$bits(mode_t)-1:0]);
            if (reg_wr && reg_addr == RA_WRAP && !busy) begin
                endp_q <= reg_wdata[IDXW-1:0];
                csiv_q <= reg_wdata[8];
            end
            if (reg_wr && reg_addr == RA_ADDR) begin
                region_q <= reg_wdata[5:4];
                sw_idx   <= reg_wdata[IDXW-1:0];
            end else if (data_acc) begin
                sw_idx <= sw_idx + IDXW'(1);
            end
            if (finish)
                done_q <= 1'b1;
            else if (reg_wr && reg_addr == RA_STAT && reg_wdata[0])
                done_q <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_MODE: reg_rdata[$bits(mode_t)-1:0] = mode_q;
            RA_CTRL: reg_rdata[0] = busy;
            RA_WRAP: begin
                reg_rdata[IDXW-1:0] = endp_q;
                reg_rdata[8]        = csiv_q;
            end
            RA_STAT: reg_rdata[0] = done_q;
            RA_ADDR: begin
                reg_rdata[5:4]      = region_q;
                reg_rdata[IDXW-1:0] = sw_idx;
            end
            RA_DATA: begin
                case (region_q)
                    RG_TX:   reg_rdata = ram_rd[0];
                    RG_RX:   reg_rdata = ram_rd[1];
                    RG_CMD:  reg_rdata = ram_rd[2];
                    default: reg_rdata = '0;
                endcase
            end
            default: reg_rdata = '0;
        endcase
    end

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        finish |=> done_q); // R3

    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(mode_q)); // R9

endmodule

// File: rtl/sbm_engine.sv
module sbm_engine
    import sbm_pkg::*;
#(
    parameter int QDEPTH = 16,
    localparam int IDXW  = $clog2(QDEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             cpol,
    input  logic             cpha,
    input  logic [3:0]       bits,
    input  logic             csiv,
    input  logic [IDXW-1:0]  endp,
    input  cmd_t             cmd,
    input  logic [REG_W-1:0] txw,
    input  logic             tick,
    input  logic             miso,
    output logic [IDXW-1:0]  idx,
    output logic             rx_we,
    output logic [REG_W-1:0] rx_data,
    output logic             busy,
    output logic             finish,
    output logic             sck,
    output logic             mosi,
    output logic [CS_N-1:0]  cs
);

    eng_state_e       state;
    logic [LEN_W-1:0] len;
    logic [LEN_W-1:0] bitcnt;
    logic [LEN_W-1:0] cur_len;
    logic [REG_W-1:0] tx_al;
    logic [REG_W-1:0] txsh;
    logic [REG_W-1:0] rxsh;
    logic             cont_q;
    logic             sck_q;
    logic             mosi_q;
    logic [CS_N-1:0]  cs_q;
    logic             last_bit;

    assign cur_len  = entry_len(cmd.bitse, bits);
    assign tx_al    = txw << (LEN_W'(REG_W) - cur_len);
    assign last_bit = (bitcnt == len - LEN_W'(1));

    assign busy    = (state != ST_IDLE);
    assign rx_we   = (state == ST_NEXT);
    assign rx_data = rxsh;
    assign finish  = (state == ST_NEXT) && (idx == endp);
    assign sck     = busy ? sck_q : cpol;
    assign mosi    = mosi_q;
    assign cs      = busy ? cs_q : {CS_N{csiv}};

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            idx    <= '0;
            len    <= '0;
            bitcnt <= '0;
            txsh   <= '0;
            rxsh   <= '0;
            cont_q <= 1'b0;
            sck_q  <= 1'b0;
            mosi_q <= 1'b0;
            cs_q   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        idx   <= '0;
                        sck_q <= cpol;
                        cs_q  <= {CS_N{csiv}};
                        state <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    len    <= cur_len;
                    bitcnt <= '0;
                    rxsh   <= '0;
                    cont_q <= cmd.cont;
                    for (int i = 0; i < CS_N; i++)
                        cs_q[i] <= cmd.sel[i] ? ~csiv : csiv;
                    if (!cpha) begin
                        mosi_q <= tx_al[REG_W-1];
                        txsh   <= tx_al << 1;
                    end else begin
                        txsh   <= tx_al;
                    end
                    state <= ST_LEAD;
                end
                ST_LEAD: begin
                    if (tick) begin
                        sck_q <= ~cpol;
                        if (!cpha) begin
                            rxsh <= {rxsh[REG_W-2:0], miso};
                        end else begin
                            mosi_q <= txsh[REG_W-1];
                            txsh   <= txsh << 1;
                        end
                        state <= ST_TRAIL;
                    end
                end
                ST_TRAIL: begin
                    if (tick) begin
                        sck_q <= cpol;
                        if (cpha) begin
                            rxsh <= {rxsh[REG_W-2:0], miso};
                        end else if (!last_bit) begin
                            mosi_q <= txsh[REG_W-1];
                            txsh   <= txsh << 1;
                        end
                        bitcnt <= bitcnt + LEN_W'(1);
                        state  <= last_bit ? ST_NEXT : ST_LEAD;
                    end
                end
                ST_NEXT: begin
                    if (idx == endp) begin
                        cs_q   <= {CS_N{csiv}};
                        mosi_q <= 1'b0;
                        state  <= ST_IDLE;
                    end else if (cont_q) begin
                        idx   <= idx + IDXW'(1);
                        state <= ST_LOAD;
                    end else begin
                        cs_q  <= {CS_N{csiv}};
                        state <= ST_GAP;
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        idx   <= idx + IDXW'(1);
                        state <= ST_LOAD;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_GAP_CS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_GAP) |-> (cs == {CS_N{csiv}})); // R8

    AST_LOAD_SCK_REST: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOAD) |-> (sck == cpol)); // R5

    AST_IDX_LIMIT: assert property (@(posedge clk) disable iff (rst)
        busy |-> (idx <= endp)); // R10

    AST_BIT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TRAIL) |-> (bitcnt < len)); // R6

endmodule

// File: rtl/sbm_top.sv
module sbm_top
    import sbm_pkg::*;
#(
    parameter int QDEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [2:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             spi_sck,
    output logic             spi_mosi,
    input  logic             spi_miso,
    output logic [CS_N-1:0]  spi_cs_o
);

    localparam int IDXW = $clog2(QDEPTH);

    mode_t                         mode_q;
    logic                          csiv;
    logic [IDXW-1:0]               endp;
    logic                          start;
    logic [NUM_RGN-1:0]            sw_we;
    logic [IDXW-1:0]               sw_idx;
    logic [NUM_RGN-1:0][REG_W-1:0] ram_rd;
    logic [IDXW-1:0]               eng_idx;
    logic                          eng_rx_we;
    logic [REG_W-1:0]              eng_rx_data;
    logic                          busy;
    logic                          finish;
    logic                          tick;
    logic [IDXW-1:0]               rd_idx;

    assign rd_idx = busy ? eng_idx : sw_idx;

    sbm_regfile #(.QDEPTH(QDEPTH)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .finish    (finish),
        .ram_rd    (ram_rd),
        .mode_q    (mode_q),
        .csiv_q    (csiv),
        .endp_q    (endp),
        .start     (start),
        .sw_we     (sw_we),
        .sw_idx    (sw_idx)
    );

    for (genvar g = 0; g < NUM_RGN; g++) begin : g_ram
        logic             we_g;
        logic [IDXW-1:0]  wa_g;
        logic [REG_W-1:0] wd_g;
        if (g == int'(RG_RX)) begin : g_rx
            assign we_g = sw_we[g] | eng_rx_we;
            assign wa_g = eng_rx_we ? eng_idx : sw_idx;
            assign wd_g = eng_rx_we ? eng_rx_data : reg_wdata;
        end else begin : g_sw
            assign we_g = sw_we[g];
            assign wa_g = sw_idx;
            assign wd_g = reg_wdata;
        end
        sbm_qram #(.DEPTH(QDEPTH), .WIDTH(REG_W)) u_ram (
            .clk   (clk),
            .we    (we_g),
            .waddr (wa_g),
            .wdata (wd_g),
            .raddr (rd_idx),
            .rdata (ram_rd[g])
        );
    end

    sbm_tick u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .div  (mode_q.div),
        .tick (tick)
    );

    sbm_engine #(.QDEPTH(QDEPTH)) u_eng (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .cpol    (mode_q.cpol),
        .cpha    (mode_q.cpha),
        .bits    (mode_q.bits),
        .csiv    (csiv),
        .endp    (endp),
        .cmd     (cmd_t'(ram_rd[int'(RG_CMD)][$bits(cmd_t)-1:0])),
        .txw     (ram_rd[int'(RG_TX)]),
        .tick    (tick),
        .miso    (spi_miso),
        .idx     (eng_idx),
        .rx_we   (eng_rx_we),
        .rx_data (eng_rx_data),
        .busy    (busy),
        .finish  (finish),
        .sck     (spi_sck),
        .mosi    (spi_mosi),
        .cs      (spi_cs_o)
    );

endmodule

// File: tb/sbm_top_tb_top.sv
module sbm_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        spi_sck, spi_mosi, spi_miso;
    logic [3:0]  spi_cs_o;
    logic        inv = 1'b0;

    always #10ns clk = ~clk;

    assign spi_miso = spi_mosi ^ inv;

    sbm_top dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_cs_o(spi_cs_o)
    );

    int checks = 0;
    int errs   = 0;

    logic [15:0] tb_tx  [16];
    logic [5:0]  tb_cmd [16];
    int          tb_len [16];

    // monitor state
    int   cyc = 0;
    logic cur_cpol = 1'b0;
    logic cur_cpha = 1'b0;
    logic csiv_cur = 1'b1;
    int   mon_line = 0;
    logic mon_bits [0:1023];
    int   mon_n = 0;
    int   edges = 0;
    int   lead_t = 0;
    int   last_half = 0;
    int   cs_rel = 0;
    logic prev_sck = 1'b0;
    logic prev_cs = 1'b1;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst && spi_sck !== prev_sck) begin
            if (spi_sck != cur_cpol) lead_t = cyc;
            else last_half = cyc - lead_t;
            if ((spi_sck != cur_cpol) ^ cur_cpha) begin
                mon_bits[mon_n] = spi_mosi;
                mon_n++;
            end
            edges++;
        end
        if (!rst && prev_cs == ~csiv_cur && spi_cs_o[mon_line] == csiv_cur)
            cs_rel++;
        prev_sck = spi_sck;
        prev_cs  = spi_cs_o[mon_line];
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1ns d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic set_mode(input logic [15:0] m);
        cur_cpol = m[13];
        cur_cpha = m[12];
        wr(3'd0, m);
        for (int i = 0; i < 16; i++)
            tb_len[i] = !tb_cmd[i][4] ? 8 : (m[11:8] == 0 ? 16 : int'(m[11:8]));
    endtask

    task automatic prog(input int n, input logic cv);
        csiv_cur = cv;
        wr(3'd4, 16'h0020);
        for (int i = 0; i < n; i++) wr(3'd5, {10'd0, tb_cmd[i]});
        wr(3'd4, 16'h0000);
        for (int i = 0; i < n; i++) wr(3'd5, tb_tx[i]);
        wr(3'd2, {7'd0, cv, 4'd0, 4'(n - 1)});
    endtask

    task automatic mon_clear();
        @(negedge clk);
        mon_n = 0; edges = 0; cs_rel = 0;
    endtask

    task automatic wait_done(input string tag);
        logic [15:0] d;
        d = '0;
        for (int i = 0; i < 20000; i++) begin
            rd(3'd3, d);
            if (d[0]) break;
        end
        chk({tag, " done flag"}, {31'd0, d[0]}, 32'd1);
    endtask

    task automatic run(input int n, input logic cv, input string tag);
        prog(n, cv);
        mon_clear();
        wr(3'd1, 16'h0001);
        wait_done(tag);
        wr(3'd3, 16'h0001);
    endtask

    task automatic chk_rx(input int n, input string tag);
        logic [15:0] d, msk;
        wr(3'd4, 16'h0010);
        for (int i = 0; i < n; i++) begin
            rd(3'd5, d);
            msk = (tb_len[i] == 16) ? 16'hFFFF : 16'((1 << tb_len[i]) - 1);
            chk({tag, " rx word"}, {16'd0, d}, {16'd0, (tb_tx[i] ^ {16{inv}}) & msk});
        end
    endtask

    task automatic chk_stream(input int n, input string tag);
        int k, bad;
        k = 0; bad = 0;
        for (int e = 0; e < n; e++)
            for (int b = tb_len[e] - 1; b >= 0; b--) begin
                if (mon_bits[k] !== tb_tx[e][b]) bad++;
                k++;
            end
        chk({tag, " mosi bit errors"}, bad, 0);
        chk({tag, " mosi bit count"}, mon_n, k);
    endtask

    task automatic t_reset();
        logic [15:0] d;
        chk("R8 reset cs idle", {28'd0, spi_cs_o}, 32'hF);
        chk("R5 reset sck", {31'd0, spi_sck}, 0);
        rd(3'd0, d); chk("R1 reset mode", {16'd0, d}, 32'h0000);
        rd(3'd2, d); chk("R1 reset queue-limit", {16'd0, d}, 32'h0100);
        rd(3'd3, d); chk("R3 reset status", {16'd0, d}, 0);
    endtask

    task automatic t_regs();
        logic [15:0] d;
        wr(3'd4, 16'h0000);
        wr(3'd5, 16'h0011); wr(3'd5, 16'h0022); wr(3'd5, 16'h0033);
        rd(3'd4, d); chk("R1 index stepped", {16'd0, d}, 32'h0003);
        wr(3'd4, 16'h0001);
        rd(3'd5, d); chk("R1 readback entry1", {16'd0, d}, 32'h0022);
        rd(3'd5, d); chk("R1 readback entry2", {16'd0, d}, 32'h0033);
        wr(3'd4, 16'h0030);
        rd(3'd5, d); chk("R1 region none reads 0", {16'd0, d}, 0);
    endtask

    task automatic t_mode0();
        logic [15:0] d;
        tb_cmd[0] = 6'h21; tb_cmd[1] = 6'h21; tb_cmd[2] = 6'h21;
        tb_tx[0] = 16'h00A5; tb_tx[1] = 16'h003C; tb_tx[2] = 16'h00F0;
        inv = 1'b1;
        set_mode(16'h4802);
        prog(3, 1'b1);
        mon_clear();
        wr(3'd1, 16'h0001);
        rd(3'd1, d); chk("R2 go bit reads 1 while running", {31'd0, d[0]}, 1);
        wait_done("R3");
        rd(3'd1, d); chk("R2 go bit self-clears", {31'd0, d[0]}, 0);
        wr(3'd3, 16'h0000);
        rd(3'd3, d); chk("R3 writing 0 keeps flag", {31'd0, d[0]}, 1);
        wr(3'd3, 16'h0001);
        rd(3'd3, d); chk("R3 writing 1 clears flag", {31'd0, d[0]}, 0);
        chk_stream(3, "R4 mode0");
        chk_rx(3, "R4 mode0 inverted loop");
    endtask

    task automatic t_modes();
        tb_cmd[0] = 6'h21; tb_cmd[1] = 6'h21;
        tb_tx[0] = 16'h0081; tb_tx[1] = 16'h007E;
        inv = 1'b0;
        set_mode(16'h7802);
        mon_clear();
        chk("R5 sck idles high with CPOL", {31'd0, spi_sck}, 1);
        run(2, 1'b1, "R5 mode3");
        chk_stream(2, "R5 mode3");
        chk_rx(2, "R5 mode3 loop");
        tb_tx[0] = 16'h00C3;
        set_mode(16'h5802);
        run(1, 1'b1, "R5 mode1");
        chk_stream(1, "R5 mode1");
        chk_rx(1, "R5 mode1 loop");
    endtask

    task automatic t_len();
        tb_cmd[0] = 6'h31; tb_cmd[1] = 6'h21;
        tb_tx[0] = 16'h0ABC; tb_tx[1] = 16'h0ABC;
        inv = 1'b1;
        set_mode(16'h4C02);
        run(2, 1'b1, "R6 12-bit");
        chk_stream(2, "R6 mixed lengths");
        chk_rx(2, "R6 mixed lengths");
        tb_cmd[0] = 6'h31; tb_tx[0] = 16'h1234;
        set_mode(16'h4002);
        run(1, 1'b1, "R6 16-bit");
        chk_stream(1, "R6 zero means 16");
        chk_rx(1, "R6 zero means 16");
    endtask

    task automatic t_div();
        tb_cmd[0] = 6'h21; tb_tx[0] = 16'h0055; inv = 1'b0;
        set_mode(16'h4807);
        run(1, 1'b1, "R7 div7");
        chk("R7 half period div 7", last_half, 14);
        set_mode(16'h4800);
        run(1, 1'b1, "R7 div0");
        chk("R7 half period clamp", last_half, 4);
    endtask

    task automatic t_cs();
        for (int i = 0; i < 3; i++) begin tb_cmd[i] = 6'h22; tb_tx[i] = 16'(i + 1); end
        inv = 1'b0; mon_line = 1;
        set_mode(16'h4802);
        run(3, 1'b1, "R8 cont");
        chk("R8 continue keeps select", cs_rel, 1);
        for (int i = 0; i < 3; i++) tb_cmd[i] = 6'h02;
        run(3, 1'b1, "R8 no-cont");
        chk("R8 select drops between entries", cs_rel, 3);
        tb_cmd[0] = 6'h24; tb_cmd[1] = 6'h24; mon_line = 2;
        set_mode(16'h4814);
        prog(2, 1'b0);
        mon_clear();
        chk("R8 idle level low", {28'd0, spi_cs_o}, 0);
        wr(3'd1, 16'h0001);
        repeat (30) @(negedge clk);
        chk("R8 asserted high pattern", {28'd0, spi_cs_o}, 32'h4);
        wait_done("R8 csiv0");
        wr(3'd3, 16'h0001);
        chk("R8 idle after queue", {28'd0, spi_cs_o}, 0);
        wr(3'd2, 16'h0100);
        csiv_cur = 1'b1;
    endtask

    task automatic t_ignore();
        logic [15:0] d;
        tb_cmd[0] = 6'h31; tb_cmd[1] = 6'h31;
        tb_tx[0] = 16'h005A; tb_tx[1] = 16'h006B;
        set_mode(16'h4814);
        prog(2, 1'b1);
        wr(3'd1, 16'h0001);
        wr(3'd0, 16'h4802);
        wr(3'd2, 16'h0005);
        wr(3'd4, 16'h0000);
        wr(3'd5, 16'h00EE);
        wait_done("R9");
        wr(3'd3, 16'h0001);
        rd(3'd0, d); chk("R9 mode write ignored", {16'd0, d}, 32'h4814);
        rd(3'd2, d); chk("R9 queue-limit write ignored", {16'd0, d}, 32'h0101);
        wr(3'd4, 16'h0000);
        rd(3'd5, d); chk("R9 transmit write ignored", {16'd0, d}, 32'h005A);
        // master enable clear: go has no effect
        set_mode(16'h0802);
        mon_clear();
        wr(3'd1, 16'h0001);
        repeat (20) @(negedge clk);
        rd(3'd1, d); chk("R2 no start without master enable", {31'd0, d[0]}, 0);
        chk("R2 no clock edges without master enable", edges, 0);
    endtask

    task automatic t_full();
        for (int i = 0; i < 16; i++) begin
            tb_cmd[i] = 6'h21;
            tb_tx[i]  = 16'(i * 17 + 3);
        end
        inv = 1'b1;
        set_mode(16'h4802);
        run(16, 1'b1, "R10 full");
        chk_stream(16, "R10 sixteen entries");
        chk_rx(16, "R10 sixteen entries");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regs();
        t_mode0();
        t_modes();
        t_len();
        t_div();
        t_cs();
        t_ignore();
        t_full();
        $display("CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end

endmodule